// File: doc/BRIEF.md
# Serial Flash SPI Master

This block is an SPI master for a serial flash device, driven through a small 32-bit register port. Software pushes bytes into an 8-entry transmit queue. The block sends each byte as one serial frame. When the receive direction is selected, the block stores the byte that came back during that frame in an 8-entry receive queue, where software can pop it. Programmable settings cover the serial clock rate, clock idle level and sampling edge, lane width (one, two or four data lines), bit order and frame length.

A chip-select mode decides how the select line behaves. In the per-frame mode, select is asserted for each frame and released after it. In the held mode, select stays low across any number of frames, for example a command, an address and its data. In the off mode, select is never asserted. Queue state reaches software in two ways. The sign bit of a queue data read reports it, and two watermark pending bits report it as well. Setup, hold and inter-frame delays are fixed at one half serial-clock period each.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, select is high, the serial clock is low, no data line is driven, the pending word reads 0 and a receive-queue read returns bit 31 set. Reset also selects per-frame select mode, transmit direction, divider 3, MSB-first single-lane order and 8-bit frames.
- R2: The serial clock period is 2 × (divider + 1) system clocks. The divider is written at offset 0x00.
- R3: Bit 0 of the clock-mode register (offset 0x04) sets the idle level of the clock. Bit 1 selects sampling on the first edge of each bit (0) or on the second edge (1). With data looped back from the output lane, a received byte equals the sent byte in all four clock modes.
- R4: Bit 2 of the format register (offset 0x40) selects MSB first (0) or LSB first (1) on the wire.
- R5: Format bits [1:0] select 1, 2 or 4 lanes (codes 0, 1, 2). In single-lane mode, data goes out on line 0 and comes in on line 1. In dual or quad mode, in each beat the most significant bits of the remaining data sit on the highest line. The lines are driven only in transmit direction. Format bits [19:16] hold the frame length in bits.
- R6: Format bit 3 set (transmit) discards incoming data. Bit 3 clear (receive) pushes one byte into the receive queue per frame.
- R7: A read of the transmit data word (offset 0x48) returns bit 31 set while the queue holds 8 entries. A write made while the queue is full is dropped, and the queued entries are left unchanged.
- R8: A read of the receive data word (offset 0x4C) returns bit 31 set when the queue is empty. Otherwise the read returns the oldest byte in bits [7:0] and removes it. Bytes leave in the order they arrived.
- R9: Pending bit 0 (offset 0x74) is set while the transmit queue holds fewer entries than the transmit watermark (offset 0x50).
- R10: Pending bit 1 is set while the receive queue holds more entries than the receive watermark (offset 0x54).
- R11: The select-mode register (offset 0x18) uses these codes. 0: select low from before the first clock edge of a frame until after its last edge, then high between frames. 2: select low at all times. 3: select high at all times.
- R12: A frame that completes in the same cycle as a receive-queue read stores its byte, and the read still returns the previous oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 4 | Data lines, output values |
| dq_oe | output | 4 | Data lines, output enables |
| dq_in | input | 4 | Data lines, input values |

## Verification
The collision of interest is a frame finishing, which pushes a received byte, in the same cycle that software pops the receive queue. The bench loops the output lane back to the input and runs the fastest clock, so a frame takes 20 system clocks. It then polls the queue on a period a little shorter than a frame while it keeps refilling the transmit side. As a result, the pop drifts through every phase of the frame and lands on the push cycle at least once. The result is judged on the full ordered list of bytes that come back, which must match the sent list exactly, with no byte lost or repeated.

// File: rtl/spi_flash_master.sv
module spi_flash_master #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 12,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sck,
  output logic          cs_n,
  output logic [3:0]    dq_out,
  output logic [3:0]    dq_oe,
  input  logic [3:0]    dq_in
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] A_DIV = 'h00, A_CLK = 'h04, A_SEL = 'h18, A_FMT = 'h40,
                            A_TXD = 'h48, A_RXD = 'h4C, A_TXW = 'h50, A_RXW = 'h54,
                            A_PND = 'h74;
  localparam logic [1:0] SEL_HOLD = 2'd2, SEL_OFF = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_TAIL, S_GAP} state_t;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  logic [DIV_W-1:0] div_q, dcnt;
  logic             cpol, cpha, lsb, dir_tx;
  logic [1:0]       selmode, proto;
  logic [3:0]       flen;
  logic [CW-1:0]    txwm, rxwm;

  wire wr = bus_sel & bus_we;
  wire rd = bus_sel & ~bus_we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= DIV_W'(3); cpol <= 1'b0; cpha <= 1'b0; selmode <= 2'd0;
      proto <= 2'd0; lsb <= 1'b0; dir_tx <= 1'b1; flen <= 4'd8;
      txwm <= '0; rxwm <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_DIV: div_q <= bus_wdata[DIV_W-1:0];
        A_CLK: {cpha, cpol} <= bus_wdata[1:0];
        A_SEL: selmode <= bus_wdata[1:0];
        A_FMT: begin
          proto <= bus_wdata[1:0]; lsb <= bus_wdata[2];
          dir_tx <= bus_wdata[3]; flen <= bus_wdata[19:16];
        end
        A_TXW: txwm <= bus_wdata[CW-1:0];
        A_RXW: rxwm <= bus_wdata[CW-1:0];
        default: ;
      endcase
    end

  // transmit queue
  logic [7:0]    txm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  wire tx_push = wr && bus_addr == A_TXD && tx_cnt != CW'(DEPTH);
  logic tx_pop;

  always_ff @(posedge clk) if (tx_push) txm[tx_wp] <= bus_wdata[7:0];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == PW'(DEPTH-1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == PW'(DEPTH-1)) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  // frame sequencer
  state_t     st;
  logic       sck_r, in_frame, f_lsb;
  logic [1:0] f_lg;
  logic [3:0] f_len;
  logic [4:0] hcnt;
  logic [7:0] txsh, rxsh;

  wire       tick = (dcnt == div_q);
  wire [3:0] beats_raw = f_len >> f_lg;
  wire [3:0] beats = (beats_raw == 4'd0) ? 4'd1 : beats_raw;
  wire [4:0] halves = {beats, 1'b0};
  wire       lead_edge = ~hcnt[0];
  wire       do_sample = lead_edge ^ cpha;
  wire       do_drive = ~do_sample && !(cpha && hcnt == 5'd0);
  wire [3:0] len_now = (flen == 4'd0 || flen > 4'd8) ? 4'd8 : flen;
  wire [1:0] lg_now = (proto == 2'd2) ? 2'd2 : (proto == 2'd1) ? 2'd1 : 2'd0;
  wire [7:0] rx_byte = f_lsb ? (rev8(rxsh) >> (4'd8 - f_len)) : rxsh;
  wire       frame_end = (st == S_TAIL) && tick;

  assign tx_pop = (st == S_IDLE) && tx_cnt != '0;

  logic [7:0] rx_next, tx_next;
  always_comb
    case (f_lg)
      2'd0:    begin rx_next = {rxsh[6:0], dq_in[1]};   tx_next = {txsh[6:0], 1'b0}; end
      2'd1:    begin rx_next = {rxsh[5:0], dq_in[1:0]}; tx_next = {txsh[5:0], 2'b0}; end
      default: begin rx_next = {rxsh[3:0], dq_in};      tx_next = {txsh[3:0], 4'b0}; end
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; dcnt <= '0; sck_r <= 1'b0; in_frame <= 1'b0; hcnt <= '0;
      txsh <= '0; rxsh <= '0; f_lg <= '0; f_len <= 4'd8; f_lsb <= 1'b0;
    end else begin
      dcnt <= (st == S_IDLE || tick) ? '0 : dcnt + 1'b1;
      case (st)
        S_IDLE: begin
          sck_r <= cpol;
          if (tx_pop) begin
            txsh <= lsb ? rev8(txm[tx_rp]) : txm[tx_rp];
            rxsh <= '0; f_lg <= lg_now; f_len <= len_now; f_lsb <= lsb;
            in_frame <= 1'b1; st <= S_LEAD;
          end
        end
        S_LEAD: if (tick) begin hcnt <= '0; st <= S_SHIFT; end
        S_SHIFT: if (tick) begin
          sck_r <= ~sck_r;
          if (do_sample) rxsh <= rx_next;
          if (do_drive) txsh <= tx_next;
          hcnt <= hcnt + 1'b1;
          if (hcnt == halves - 5'd1) st <= S_TAIL;
        end
        S_TAIL: if (tick) begin in_frame <= 1'b0; st <= S_GAP; end
        S_GAP:  if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign sck  = sck_r;
  assign cs_n = (selmode == SEL_HOLD) ? 1'b0 : (selmode == SEL_OFF) ? 1'b1 : ~in_frame;
  assign dq_out = (f_lg == 2'd0) ? {3'b0, txsh[7]} :
                  (f_lg == 2'd1) ? {2'b0, txsh[7:6]} : txsh[7:4];
  assign dq_oe = !in_frame ? 4'b0000 : (f_lg == 2'd0) ? 4'b0001 :
                 !dir_tx ? 4'b0000 : (f_lg == 2'd1) ? 4'b0011 : 4'b1111;

  // receive queue
  logic [7:0]    rxm [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  wire rx_push = frame_end && !dir_tx && rx_cnt != CW'(DEPTH);
  wire rx_pop  = rd && bus_addr == A_RXD && rx_cnt != '0;

  always_ff @(posedge clk) if (rx_push) rxm[rx_wp] <= rx_byte;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == PW'(DEPTH-1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == PW'(DEPTH-1)) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  // registered read port
  wire tx_pend = tx_cnt < txwm;
  wire rx_pend = rx_cnt > rxwm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (rd)
      case (bus_addr)
        A_DIV: bus_rdata <= 32'(div_q);
        A_CLK: bus_rdata <= {30'b0, cpha, cpol};
        A_SEL: bus_rdata <= {30'b0, selmode};
        A_FMT: bus_rdata <= {12'b0, flen, 12'b0, dir_tx, lsb, proto};
        A_TXD: bus_rdata <= {tx_cnt == CW'(DEPTH), 31'b0};
        A_RXD: bus_rdata <= (rx_cnt == '0) ? 32'h8000_0000 : {24'b0, rxm[rx_rp]};
        A_TXW: bus_rdata <= 32'(txwm);
        A_RXW: bus_rdata <= 32'(rxwm);
        A_PND: bus_rdata <= {30'b0, rx_pend, tx_pend};
        default: bus_rdata <= '0;
      endcase

  p_tx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  p_tx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && wr && bus_addr == A_TXD && st != S_IDLE) |=> tx_cnt == CW'(DEPTH));
  p_tx_full_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_TXD && tx_cnt == CW'(DEPTH)) |=> bus_rdata[31]);
  p_rx_empty_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_RXD && rx_cnt == '0) |=> bus_rdata[31]);
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dir_tx |=> rx_cnt <= $past(rx_cnt));
  p_auto_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (selmode == 2'd0 && st == S_IDLE) |-> cs_n);
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st == S_IDLE)) |-> sck == $past(cpol));
endmodule

// File: tb/spi_flash_master_test.sv
`timescale 1ns/1ps
module spi_flash_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, cs_n;
  logic [3:0] dq_out, dq_oe, dq_in, fixed_in = 4'h0;
  logic loop = 1'b0;
  int nchk = 0, nfail = 0, cur_div = 3;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign dq_in = loop ? {2'b00, dq_out[0], 1'b0} : fixed_in;

  spi_flash_master uut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .sck, .cs_n, .dq_out, .dq_oe, .dq_in);

  localparam logic [7:0] DIV = 8'h00, CLKM = 8'h04, SELM = 8'h18, FMT = 8'h40,
                         TXD = 8'h48, RXD = 8'h4C, TXW = 8'h50, RXW = 8'h54, PND = 8'h74;

  function automatic logic [31:0] fmt(input int len, input bit tx, input bit lsbf, input int pr);
    return (32'(len) << 16) | (32'(tx) << 3) | (32'(lsbf) << 2) | 32'(pr);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    if (a == DIV) cur_div = int'(d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic drain();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(PND, v);
      if (v[0]) break;
    end
    repeat (25 * (cur_div + 1) + 5) @(posedge clk);
  endtask

  task automatic flush_rx();
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(RXD, v);
      if (v[31]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(cs_n === 1'b1, "R1 cs_n", 32'(cs_n), 1);
    check(sck === 1'b0, "R1 sck", 32'(sck), 0);
    check(dq_oe === 4'h0, "R1 dq_oe", 32'(dq_oe), 0);
    rd(PND, v); check(v === 32'h0, "R1 pending", v, 0);
    rd(RXD, v); check(v[31] === 1'b1, "R1 rx empty", v, 32'h8000_0000);
    rd(FMT, v); check(v === fmt(8, 1, 0, 0), "R1 format", v, fmt(8, 1, 0, 0));
  endtask

  task automatic t_divider();
    time t0, t1;
    wr(TXW, 1);
    fork wr(TXD, 8'hA5); begin @(posedge sck); t0 = $time; @(posedge sck); t1 = $time; end join
    check(t1 - t0 == 32, "R2 period div3", 32'(t1 - t0), 32);
    drain();
    wr(DIV, 1);
    fork wr(TXD, 8'h5A); begin @(posedge sck); t0 = $time; @(posedge sck); t1 = $time; end join
    check(t1 - t0 == 16, "R2 period div1", 32'(t1 - t0), 16);
    drain();
  endtask

  task automatic t_clock_modes();
    logic [31:0] v;
    loop = 1; wr(DIV, 0); wr(FMT, fmt(8, 0, 0, 0));
    for (int m = 0; m < 4; m++) begin
      wr(CLKM, 32'(m));
      wr(TXD, 32'(8'h3C + m));
      drain();
      check(sck === m[0], "R3 idle level", 32'(sck), 32'(m[0]));
      rd(RXD, v); check(v === 32'(8'h3C + m), "R3 loopback byte", v, 32'(8'h3C + m));
    end
    wr(CLKM, 0);
  endtask

  task automatic t_order();
    logic [7:0] b;
    wr(DIV, 2); wr(FMT, fmt(8, 1, 0, 0));
    fork wr(TXD, 8'h1E); begin @(negedge cs_n); repeat (8) begin @(posedge sck); b = {b[6:0], dq_out[0]}; end end join
    check(b === 8'h1E, "R4 msb first", 32'(b), 32'h1E);
    drain();
    wr(FMT, fmt(8, 1, 1, 0));
    fork wr(TXD, 8'h1E); begin @(negedge cs_n); repeat (8) begin @(posedge sck); b = {b[6:0], dq_out[0]}; end end join
    check(b === 8'h78, "R4 lsb first", 32'(b), 32'h78);
    drain();
  endtask

  task automatic t_lanes();
    logic [31:0] v;
    loop = 0; wr(DIV, 1);
    fixed_in = 4'h5; wr(FMT, fmt(8, 0, 0, 2));
    fork wr(TXD, 8'h00); begin @(negedge cs_n); @(negedge clk); check(dq_oe === 4'h0, "R5 quad rx not driven", 32'(dq_oe), 0); end join
    drain(); rd(RXD, v); check(v === 32'h55, "R5 quad receive", v, 32'h55);
    fixed_in = 4'h2; wr(FMT, fmt(8, 0, 0, 1));
    wr(TXD, 8'h00); drain(); rd(RXD, v); check(v === 32'hAA, "R5 dual receive", v, 32'hAA);
    fixed_in = 4'h0; wr(FMT, fmt(8, 1, 0, 2));
    fork wr(TXD, 8'hC3); begin @(negedge cs_n); @(negedge clk);
      check(dq_oe === 4'hF, "R5 quad tx drive", 32'(dq_oe), 32'hF);
      check(dq_out === 4'hC, "R5 quad first nibble", 32'(dq_out), 32'hC); end join
    drain();
    loop = 1; wr(FMT, fmt(4, 0, 0, 0));
    wr(TXD, 8'hB0); drain(); rd(RXD, v); check(v === 32'h0B, "R5 4-bit frame", v, 32'h0B);
  endtask

  task automatic t_discard();
    logic [31:0] v;
    loop = 1; wr(FMT, fmt(8, 1, 0, 0));
    wr(TXD, 8'h11); wr(TXD, 8'h22); drain();
    rd(RXD, v); check(v[31] === 1'b1, "R6 transmit discards", v, 32'h8000_0000);
  endtask

  task automatic t_full();
    logic [31:0] v;
    logic [7:0] got [0:15];
    int ng = 0;
    loop = 1; wr(DIV, 20); wr(FMT, fmt(8, 0, 0, 0));
    for (int i = 0; i < 10; i++) wr(TXD, 32'(8'h10 + i));
    rd(TXD, v); check(v[31] === 1'b1, "R7 full flag", v, 32'h8000_0000);
    for (int i = 0; i < 20000 && ng < 12; i++) begin
      rd(RXD, v);
      if (!v[31]) begin got[ng] = v[7:0]; ng++; end
      rd(PND, v);
      if (v[0] && i > 200) begin drain(); flush_rx_collect(got, ng); break; end
    end
    check(ng == 9, "R7 accepted count", 32'(ng), 9);
    for (int i = 0; i < 9 && i < ng; i++)
      check(got[i] === 8'h10 + 8'(i), "R8 order", 32'(got[i]), 32'(8'h10 + i));
    rd(TXD, v); check(v[31] === 1'b0, "R7 not full", v, 0);
  endtask

  task automatic flush_rx_collect(inout logic [7:0] got [0:15], inout int ng);
    logic [31:0] v;
    for (int i = 0; i < 10; i++) begin
      rd(RXD, v);
      if (v[31]) break;
      if (ng < 16) begin got[ng] = v[7:0]; ng++; end
    end
  endtask

  task automatic t_watermarks();
    logic [31:0] v;
    wr(DIV, 20); wr(TXW, 1);
    rd(PND, v); check(v[0] === 1'b1, "R9 empty below mark", v, 1);
    wr(TXD, 8'h01); wr(TXD, 8'h02); repeat (4) @(posedge clk);
    rd(PND, v); check(v[0] === 1'b0, "R9 one held", v, 0);
    drain(); flush_rx();
    wr(DIV, 0); wr(RXW, 1);
    wr(TXD, 8'h03); drain();
    rd(PND, v); check(v[1] === 1'b0, "R10 one entry", v, 32'h1);
    wr(TXD, 8'h04); drain();
    rd(PND, v); check(v[1] === 1'b1, "R10 two entries", v, 32'h3);
    flush_rx(); wr(RXW, 0);
  endtask

  task automatic t_select();
    int lows = 0, highs = 0;
    wr(DIV, 1); wr(FMT, fmt(8, 1, 0, 0));
    wr(SELM, 2); repeat (3) @(posedge clk);
    check(cs_n === 1'b0, "R11 hold idle", 32'(cs_n), 0);
    wr(TXD, 8'h9F); drain();
    check(cs_n === 1'b0, "R11 hold after frame", 32'(cs_n), 0);
    wr(SELM, 3);
    fork wr(TXD, 8'h9F); repeat (60) begin @(negedge clk); if (!cs_n) lows++; end join
    check(lows == 0, "R11 off never low", 32'(lows), 0);
    drain();
    wr(SELM, 0); lows = 0;
    fork wr(TXD, 8'h9F); begin @(negedge cs_n); repeat (30) begin @(negedge clk); if (cs_n) highs++; end end join
    check(highs == 0, "R11 auto low in frame", 32'(highs), 0);
    drain();
    check(cs_n === 1'b1, "R11 auto released", 32'(cs_n), 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    logic [7:0] exp [0:63];
    logic [7:0] got [0:63];
    int ne = 0, ng = 0;
    loop = 1; wr(DIV, 0); wr(FMT, fmt(8, 0, 0, 0)); wr(TXW, 1);
    for (int i = 0; i < 6; i++) begin wr(TXD, 32'(8'h40 + i)); exp[ne] = 8'h40 + 8'(i); ne++; end
    repeat (60) @(posedge clk);
    for (int it = 0; it < 24; it++) begin
      wr(TXD, 32'(8'h60 + it)); exp[ne] = 8'h60 + 8'(it); ne++;
      rd(RXD, v);
      if (!v[31]) begin got[ng] = v[7:0]; ng++; end
      repeat (14) @(posedge clk);
    end
    drain();
    for (int i = 0; i < 10; i++) begin
      rd(RXD, v);
      if (v[31]) break;
      got[ng] = v[7:0]; ng++;
    end
    check(ng == ne, "R12 byte count", 32'(ng), 32'(ne));
    for (int i = 0; i < ne && i < ng; i++)
      check(got[i] === exp[i], "R12 byte order", 32'(got[i]), 32'(exp[i]));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_divider();
    t_clock_modes();
    t_order();
    t_lanes();
    t_discard();
    t_full();
    t_watermarks();
    t_select();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'(1), 32'(0));
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule